// File: doc/BRIEF.md
# Event Spy Capture Controller

This block sits beside a 64-bit event stream and copies whole events into a local synchronous spy RAM. A bridge reads the stored words out later through a separate read port and forwards them to host memory. Events are framed by start and end markers that travel with each data beat. A capture always opens on a start marker, so a partial event is never stored at the head of the buffer.

A single arm pulse starts a capture. It samples the mode and the event target, and it clears the pointers, the event count and the flags. There are two modes. In counted mode the block stores a programmed number of complete events (1 to 1024). It closes the capture with a status word placed right after the last data word, and it never holds back the stream. In capture-all mode the RAM is a ring. The bridge frees words one at a time. When every word is occupied, the block raises a stall toward the acquisition source, so no data is lost.

Top module: `spy_capture`

## Requirements
- R1: After reset, and again after every arm pulse, the write pointer is 0, the done flag is low and the event count is 0. Mode and target are sampled only on the arm pulse. Beats offered before any arm are not stored.
- R2: After arm, beats are discarded until a valid beat carries the start marker. That beat is stored at address 0.
- R3: In counted mode an event target of 1 to 1023 means that many events, and the value 0 means 1024. The done flag rises once that many complete events are stored. It stays high, and no further beat is stored, until the next arm.
- R4: When a counted capture ends, a status word is written at the address that follows the last stored data word. After that, `spy_wptr` equals the address of the status word plus one. The status word layout is: bits 63:56 = 0xA5, bit 18 = mode (0 counted), bit 17 = memory full, bit 16 = truncated event, bits 15:0 = number of complete events stored, and all other bits 0.
- R5: In counted mode data may use addresses 0 to DEPTH-2, and address DEPTH-1 is kept for the status word. When a data write lands on address DEPTH-2 without reaching the target, the capture ends with the full flag set. The truncated flag is set only if that last beat did not carry the end marker.
- R6: In counted mode the stall output is never asserted.
- R7: In capture-all mode every address is used as a ring. The stall output is high while DEPTH written words have not been released. A beat offered while the stall is high is not stored.
- R8: A pulse on `rd_free` in capture-all mode releases the oldest unreleased word. When the ring was full, the stall output is low in the cycle after the pulse.
- R9: `rd_data` shows the RAM word at `rd_addr` one clock after the address is applied.
- R10: In capture-all mode the done flag never rises and no status word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | One-cycle pulse that starts a new capture |
| mode_all | input | 1 | Mode sampled at arm: 0 counted, 1 capture-all |
| evt_target | input | 10 | Event target sampled at arm, 0 means 1024 |
| in_valid | input | 1 | Stream beat valid |
| in_data | input | 64 | Stream beat data |
| in_sop | input | 1 | Beat is the first of an event |
| in_eop | input | 1 | Beat is the last of an event |
| in_stall | output | 1 | Backpressure to the stream source, capture-all mode only |
| rd_addr | input | ADDR_W | Bridge read address |
| rd_data | output | 64 | Bridge read data, one cycle latency |
| rd_free | input | 1 | Bridge releases one word (capture-all mode) |
| cap_active | output | 1 | Capture armed and not yet finished |
| cap_done | output | 1 | Counted capture finished |
| spy_wptr | output | ADDR_W+1 | Number of words written since arm |

## Verification
The hardest states to reach from the ports are the two ways a capture can stop on a full buffer. One is a counted capture whose data area fills exactly on an end marker. The other is a counted capture that fills in the middle of an event, which produces a truncated status. The bench builds a 2048-word instance and picks event lengths whose sum lands on the last data slot either on an end marker (89 events of 23 beats) or on a first beat (1023 events of 2 beats). A third hard state is the full ring in capture-all mode. The bench fills every word and holds a pending beat against the stall. It then releases one word and checks that the stalled beat lands at address 0 after the ring wraps.

// File: rtl/spy_pkg.sv
// Shared types and the status word layout for the event spy capture block.
// Assumes a 64-bit stream; the status word is built to that width.
package spy_pkg;

    localparam int SPY_DW = 64;
    localparam logic [7:0] SPY_SIG = 8'hA5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK,
        ST_EVT,
        ST_STAT,
        ST_DONE
    } spy_state_t;

    // Pack the end-of-capture status word.
    function automatic logic [SPY_DW-1:0] spy_status(
        input logic        mode,
        input logic        full,
        input logic        trunc,
        input logic [15:0] cnt
    );
        return {SPY_SIG, 37'd0, mode, full, trunc, cnt};
    endfunction

endpackage

// File: rtl/spy_ram.sv
// Simple dual-port synchronous RAM used as the spy store.
// One write port, one registered read port; read-during-write gives old data.
module spy_ram #(
    parameter int DW = 64,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/spy_ptrs.sv
// Write and read pointers for the spy store, with ring-full detection.
// Pointers carry one extra wrap bit. The read pointer only moves in
// capture-all mode and never passes the write pointer.
module spy_ptrs #(
    parameter int AW = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        mode_all,
    input  logic        wr_adv,
    input  logic        rd_free,
    output logic [AW:0] wptr,
    output logic        ring_full
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    logic [AW:0] rptr;
    logic [AW:0] used;

    // Advance the write pointer on every stored word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) wptr <= '0;
        else if (wr_adv)     wptr <= wptr + 1'b1;
    end

    // Advance the read pointer when the bridge frees a word in ring mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                             rptr <= '0;
        else if (mode_all && rd_free && (rptr != wptr))  rptr <= rptr + 1'b1;
    end

    assign used      = wptr - rptr;
    assign ring_full = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);

    // The ring never holds more than DEPTH unreleased words.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_all |-> (used <= DEPTH_V));
endmodule

// File: rtl/spy_fsm.sv
// Capture sequencer: event boundary tracking, event counting, end-of-capture
// decision and status word generation. Assumes the stream source holds a beat
// while the stall output is high.
module spy_fsm #(
    parameter int AW = 6,
    parameter int CW = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      arm,
    input  logic                      mode_all_i,
    input  logic [CW-1:0]             target_i,
    input  logic                      in_valid,
    input  logic                      in_sop,
    input  logic                      in_eop,
    input  logic [AW:0]               wptr,
    input  logic                      ring_full,
    output logic                      mode_q,
    output logic                      stall,
    output logic                      wr_en,
    output logic                      wr_status,
    output logic [spy_pkg::SPY_DW-1:0] status_word,
    output logic                      active,
    output logic                      done
);
    import spy_pkg::*;

    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] LAST_SLOT = (AW+1)'(DEPTH - 2);
    localparam logic [AW:0] DEPTH_V   = (AW+1)'(DEPTH);
    localparam logic [CW:0] MAX_EVT   = {1'b1, {CW{1'b0}}};

    spy_state_t  state;
    logic [CW:0] target_q;
    logic [CW:0] evt_cnt;
    logic [CW:0] cnt_next;
    logic        full_q;
    logic        trunc_q;
    logic        open_st;
    logic        take;
    logic        hit;
    logic        last_slot;

    assign open_st   = (state == ST_SEEK) || (state == ST_EVT);
    assign stall     = mode_q && open_st && ring_full;
    assign take      = in_valid && !stall &&
                       (((state == ST_SEEK) && in_sop) || (state == ST_EVT));
    assign cnt_next  = evt_cnt + 1'b1;
    assign hit       = in_eop && (cnt_next == target_q);
    assign last_slot = (wptr == LAST_SLOT);

    assign wr_status   = (state == ST_STAT);
    assign wr_en       = take || wr_status;
    assign status_word = spy_status(mode_q, full_q, trunc_q, 16'(evt_cnt));
    assign active      = open_st || wr_status;
    assign done        = (state == ST_DONE);

    // Sequence a capture from arm through event tracking to its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mode_q   <= 1'b0;
            target_q <= '0;
            evt_cnt  <= '0;
            full_q   <= 1'b0;
            trunc_q  <= 1'b0;
        end else if (arm) begin
            state    <= ST_SEEK;
            mode_q   <= mode_all_i;
            target_q <= (target_i == '0) ? MAX_EVT : {1'b0, target_i};
            evt_cnt  <= '0;
            full_q   <= 1'b0;
            trunc_q  <= 1'b0;
        end else begin
            case (state)
                ST_SEEK, ST_EVT: begin
                    if (take) begin
                        if (in_eop) evt_cnt <= cnt_next;
                        if (!mode_q && (hit || last_slot)) begin
                            state   <= ST_STAT;
                            full_q  <= last_slot;
                            trunc_q <= !in_eop;
                        end else begin
                            state <= in_eop ? ST_SEEK : ST_EVT;
                        end
                    end
                end
                ST_STAT: state <= ST_DONE;
                default: ;
            endcase
        end
    end

    // A capture opens only on a start marker.
    p_open_on_sop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SEEK) && wr_en) |-> in_sop);

    // Done holds until the next arm.
    p_done_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done);

    // The counted event total never passes the target.
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && (state != ST_IDLE)) |-> (evt_cnt <= target_q));

    // Counted capture never writes beyond the last address.
    p_counted_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (wptr <= DEPTH_V));

    // Ring mode never finishes.
    p_ring_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !arm) |=> !done);
endmodule

// File: rtl/spy_capture.sv
// Event spy capture controller top. Copies framed events from a 64-bit stream
// into a spy RAM in counted or capture-all mode, and serves a bridge read port.
// Assumes ADDR_W >= 2 and that the source holds a beat while in_stall is high.
module spy_capture #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              mode_all,
    input  logic [CNT_W-1:0]  evt_target,
    input  logic              in_valid,
    input  logic [63:0]       in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              in_stall,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data,
    input  logic              rd_free,
    output logic              cap_active,
    output logic              cap_done,
    output logic [ADDR_W:0]   spy_wptr
);
    logic        mode_q;
    logic        wr_en;
    logic        wr_status;
    logic        ring_full;
    logic [63:0] status_word;
    logic [63:0] wr_data;

    spy_fsm #(.AW(ADDR_W), .CW(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .mode_all_i  (mode_all),
        .target_i    (evt_target),
        .in_valid    (in_valid),
        .in_sop      (in_sop),
        .in_eop      (in_eop),
        .wptr        (spy_wptr),
        .ring_full   (ring_full),
        .mode_q      (mode_q),
        .stall       (in_stall),
        .wr_en       (wr_en),
        .wr_status   (wr_status),
        .status_word (status_word),
        .active      (cap_active),
        .done        (cap_done)
    );

    spy_ptrs #(.AW(ADDR_W)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (arm),
        .mode_all  (mode_q),
        .wr_adv    (wr_en),
        .rd_free   (rd_free),
        .wptr      (spy_wptr),
        .ring_full (ring_full)
    );

    assign wr_data = wr_status ? status_word : in_data;

    spy_ram #(.DW(64), .AW(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (spy_wptr[ADDR_W-1:0]),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // A release on a full ring lifts the stall on the next cycle.
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stall && rd_free && !arm) |=> !in_stall);

    // Counted mode never stalls the stream.
    p_counted_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !arm) |=> !in_stall);
endmodule

// File: tb/spy_capture_bench.sv
module spy_capture_bench;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic          mode_all = 1'b0;
    logic [9:0]    evt_target = '0;
    logic          in_valid = 1'b0;
    logic [63:0]   in_data = '0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic          in_stall;
    logic [AW-1:0] rd_addr = '0;
    logic [63:0]   rd_data;
    logic          rd_free = 1'b0;
    logic          cap_active;
    logic          cap_done;
    logic [AW:0]   spy_wptr;

    int total = 0;
    int fails = 0;
    int stall_seen = 0;
    logic counted_run = 1'b0;
    logic [63:0] rv;

    // One row per counted capture: target, events offered, beats per event,
    // expected event count, expected status address.
    localparam int NROW = 5;
    localparam int T_TGT   [NROW] = '{1, 3, 5, 2, 4};
    localparam int T_OFFER [NROW] = '{3, 5, 5, 4, 6};
    localparam int T_LEN   [NROW] = '{4, 2, 1, 7, 3};
    localparam int T_CNT   [NROW] = '{1, 3, 5, 2, 4};
    localparam int T_SADDR [NROW] = '{4, 6, 5, 14, 12};

    always #5 clk = ~clk;

    spy_capture #(.ADDR_W(AW), .CNT_W(10)) u_spy_capture (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode_all(mode_all),
        .evt_target(evt_target), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_stall(in_stall),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_free(rd_free),
        .cap_active(cap_active), .cap_done(cap_done), .spy_wptr(spy_wptr)
    );

    always @(negedge clk) if (counted_run && in_stall) stall_seen++;

    function automatic logic [63:0] exp_status(input logic full, input logic trunc,
                                               input int cnt);
        logic [63:0] w;
        w = '0;
        w[63:56] = 8'hA5;
        w[17] = full;
        w[16] = trunc;
        w[15:0] = 16'(cnt);
        return w;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_arm(input logic m, input logic [9:0] t);
        @(negedge clk);
        arm = 1'b1; mode_all = m; evt_target = t;
        counted_run = !m;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic beat(input logic [63:0] d, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        while (in_stall) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic send_event(input logic [63:0] base, input int len);
        for (int b = 0; b < len; b++) beat(base + 64'(b), b == 0, b == len - 1);
    endtask

    task automatic rd(input int a, output logic [63:0] d);
        @(negedge clk);
        rd_addr = AW'(a);
        @(posedge clk);
        #1 d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset done", 64'(cap_done), 64'd0);
        chk("R1 reset wptr", 64'(spy_wptr), 64'd0);
        chk("R1 reset active", 64'(cap_active), 64'd0);
        chk("R6 reset stall", 64'(in_stall), 64'd0);
        // R1 beats before any arm are not stored
        send_event(64'h77, 3);
        @(negedge clk);
        chk("R1 no store before arm", 64'(spy_wptr), 64'd0);

        // Table of counted captures (R2, R3, R4, R9)
        for (int r = 0; r < NROW; r++) begin
            do_arm(1'b0, 10'(T_TGT[r]));
            beat(64'hDEAD, 1'b0, 1'b0);
            beat(64'hBEEF, 1'b0, 1'b1);
            for (int e = 0; e < T_OFFER[r]; e++)
                send_event(64'((r + 1) * 4096 + e * 64), T_LEN[r]);
            repeat (3) @(negedge clk);
            chk("R3 table done", 64'(cap_done), 64'd1);
            chk("R4 table wptr", 64'(spy_wptr), 64'(T_SADDR[r] + 1));
            rd(T_SADDR[r], rv);
            chk("R4 table status", rv, exp_status(1'b0, 1'b0, T_CNT[r]));
            rd(0, rv);
            chk("R2 first word is sop beat", rv, 64'((r + 1) * 4096));
        end

        // R3 target 0 means 1024 events
        do_arm(1'b0, 10'd0);
        for (int e = 0; e < 1030; e++) send_event(64'(e), 1);
        repeat (3) @(negedge clk);
        chk("R3 1024 done", 64'(cap_done), 64'd1);
        chk("R3 1024 wptr", 64'(spy_wptr), 64'd1025);
        rd(1024, rv);
        chk("R3 1024 status", rv, exp_status(1'b0, 1'b0, 1024));

        // R5 data area fills exactly on an end marker
        do_arm(1'b0, 10'd0);
        for (int e = 0; e < 90; e++) send_event(64'(e * 32), 23);
        repeat (3) @(negedge clk);
        chk("R5 exact full done", 64'(cap_done), 64'd1);
        chk("R5 exact full wptr", 64'(spy_wptr), 64'(DEPTH));
        rd(DEPTH - 1, rv);
        chk("R5 exact full status", rv, exp_status(1'b1, 1'b0, 89));

        // R5 data area fills in the middle of an event
        do_arm(1'b0, 10'd0);
        for (int e = 0; e < 1100; e++) send_event(64'(e * 4), 2);
        repeat (3) @(negedge clk);
        chk("R5 trunc done", 64'(cap_done), 64'd1);
        rd(DEPTH - 1, rv);
        chk("R5 trunc status", rv, exp_status(1'b1, 1'b1, 1023));
        rd(DEPTH - 2, rv);
        chk("R9 last data word", rv, 64'(1023 * 4));
        chk("R6 no stall in counted runs", 64'(stall_seen), 64'd0);

        // R1 re-arm clears state
        do_arm(1'b0, 10'd1);
        chk("R1 rearm done cleared", 64'(cap_done), 64'd0);
        chk("R1 rearm wptr cleared", 64'(spy_wptr), 64'd0);

        // R7, R8, R10 capture-all ring
        do_arm(1'b1, 10'd5);
        beat(64'hDEAD, 1'b0, 1'b1);
        for (int e = 0; e < DEPTH / 4; e++) send_event(64'(e * 8), 4);
        @(negedge clk);
        chk("R7 ring full stall", 64'(in_stall), 64'd1);
        chk("R7 ring full wptr", 64'(spy_wptr), 64'(DEPTH));
        in_valid = 1'b1; in_data = 64'hC0FFEE; in_sop = 1'b1; in_eop = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 stalled beat not stored", 64'(spy_wptr), 64'(DEPTH));
        chk("R7 stall held", 64'(in_stall), 64'd1);
        rd_free = 1'b1;
        @(negedge clk);
        rd_free = 1'b0;
        chk("R8 stall drops after release", 64'(in_stall), 64'd0);
        @(posedge clk);
        #1 in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        @(negedge clk);
        chk("R7 wptr after wrap", 64'(spy_wptr), 64'(DEPTH + 1));
        chk("R7 stall again", 64'(in_stall), 64'd1);
        rd(0, rv);
        chk("R9 wrapped word", rv, 64'hC0FFEE);
        chk("R10 ring no done", 64'(cap_done), 64'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule